// File: doc/BRIEF.md
# Decoupled Load/Store Queue Fabric

This block is the queue fabric between an address-generating access engine and a compute engine that run apart from each other. The access engine fetches operands and pushes them into a load queue. The compute engine takes them from there in the same order. Each store is split between the two engines. The access engine pushes the target address into a store address queue, and the compute engine pushes the value into a store data queue. The fabric starts a memory write only when both of those queues hold an entry. It then pairs the two heads in order.

The compute engine does not need its own loop count. At the end of a loop the access engine pushes an end-of-data token into the load queue. The token is a tag bit carried beside the data word. The compute engine ends its loop with a branch test on the load queue head. That test is taken only when the head is a token, and a taken test removes the token. If the compute engine reads a token as an ordinary operand, an error flag is raised and the token stays in the queue. A push into a full queue is held off by a ready signal. A read from an empty load queue raises a stall.

Top module: `dq_fabric`

## Requirements
- R1: After reset all three queues are empty: `lq_ready_o`, `sa_ready_o` and `sd_ready_o` are 1, and `op_valid_o`, `wr_valid_o`, `branch_taken_o`, `eod_misuse_o` and `op_stall_o` are 0.
- R2: The load queue delivers entries in push order. `op_data_o` carries the data word and `op_eod_o` carries the token tag (1 = end-of-data). An operand read (`op_read_i`=1) of a head with tag 0 removes that head.
- R3: Each queue holds DEPTH entries (default 128). At DEPTH entries its ready output is 0, and a push offered while full is dropped: none of the pushed content enters the queue.
- R4: `wr_valid_o` is 1 exactly when both store queues are non-empty. `wr_addr_o`/`wr_data_o` are the two heads, paired in push order.
- R5: While `wr_valid_o`=1 and `wr_ready_i`=0, the write request and both heads stay unchanged. Both heads are removed in the same cycle only when `wr_valid_o` and `wr_ready_i` are both 1.
- R6: `branch_taken_o` = `eod_branch_i` AND head present AND head tag 1. A taken branch removes the token. A branch test on a data head is not taken and removes nothing.
- R7: `eod_misuse_o` = `op_read_i` AND head present AND head tag 1. Such a read does not remove the token.
- R8: `op_stall_o` is 1 when `op_read_i` or `eod_branch_i` is 1 while the load queue is empty.
- R9: An entry accepted at a rising clock edge is visible at its queue head directly after that edge, when it is first in line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lq_push_i | input | 1 | Access engine pushes a load queue entry |
| lq_data_i | input | DATA_W | Load data word |
| lq_eod_i | input | 1 | Entry is an end-of-data token |
| lq_ready_o | output | 1 | Load queue can accept a push |
| sa_push_i | input | 1 | Access engine pushes a store address |
| sa_addr_i | input | ADDR_W | Store address |
| sa_ready_o | output | 1 | Store address queue can accept a push |
| sd_push_i | input | 1 | Compute engine pushes a store value |
| sd_data_i | input | DATA_W | Store value |
| sd_ready_o | output | 1 | Store data queue can accept a push |
| op_read_i | input | 1 | Compute engine reads the head as an operand |
| eod_branch_i | input | 1 | Compute engine performs the branch-on-end-of-data test |
| op_valid_o | output | 1 | Load queue head present |
| op_data_o | output | DATA_W | Load queue head data |
| op_eod_o | output | 1 | Load queue head is a token |
| branch_taken_o | output | 1 | Branch test taken, token removed |
| eod_misuse_o | output | 1 | Token read as an operand |
| op_stall_o | output | 1 | Read or test on an empty load queue |
| wr_valid_o | output | 1 | Memory write request |
| wr_addr_o | output | ADDR_W | Memory write address |
| wr_data_o | output | DATA_W | Memory write data |
| wr_ready_i | input | 1 | Memory accepts the write |

## Verification
The flags `branch_taken_o`, `eod_misuse_o`, `op_stall_o` and `wr_valid_o` are combinational. They follow the inputs in the same cycle. Queue contents change only at the next rising edge, so a push or a removal shows at the heads and ready outputs one edge later. The bench drives inputs just after each rising edge, reads every output one time step later, and then advances a queue model by what that edge accepts. Each comparison is therefore made against the state that the previous edge produced.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_DEPTH  = 128;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_OPERAND,
    LD_TOKEN,
    LD_MISUSE,
    LD_STALL,
    LD_PASS
  } ld_act_e;
endpackage

// File: rtl/dq_fifo.sv
module dq_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  output logic         push_ready_o,
  input  logic         pop_i,
  output logic         head_valid_o,
  output logic [W-1:0] head_data_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == FULL);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty;

  assign push_ready_o = !full;
  assign head_valid_o = !empty;
  assign head_data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3: a full queue with no removal stays full
  a_r3_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop_i) |=> !push_ready_o);

  // R9: a push into an empty queue is visible after the edge
  a_r9_push_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && empty) |=> head_valid_o);
endmodule

// File: rtl/dq_load_port.sv
module dq_load_port
  import dq_pkg::*;
(
  input  logic head_valid_i,
  input  logic head_eod_i,
  input  logic read_i,
  input  logic branch_i,
  output logic pop_o,
  output logic taken_o,
  output logic misuse_o,
  output logic stall_o
);
  ld_act_e act;

  always_comb begin
    act = LD_IDLE;
    if (read_i || branch_i) begin
      if (!head_valid_i)                act = LD_STALL;
      else if (head_eod_i && branch_i)  act = LD_TOKEN;
      else if (head_eod_i)              act = LD_MISUSE;
      else if (read_i)                  act = LD_OPERAND;
      else                              act = LD_PASS;
    end
  end

  assign pop_o    = (act == LD_OPERAND) || (act == LD_TOKEN);
  assign taken_o  = (act == LD_TOKEN);
  // a token read as operand flags misuse even when the branch also fires
  assign misuse_o = read_i && head_valid_i && head_eod_i;
  assign stall_o  = (act == LD_STALL);
endmodule

// File: rtl/dq_store_pair.sv
module dq_store_pair #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pop_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i
);
  assign wr_valid_o = addr_valid_i && data_valid_i;
  assign wr_addr_o  = addr_i;
  assign wr_data_o  = data_i;
  assign pop_o      = wr_valid_o && wr_ready_i;

  // R5: a stalled write keeps its request and payload
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
endmodule

// File: rtl/dq_fabric.sv
module dq_fabric
  import dq_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DEPTH  = DEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lq_push_i,
  input  logic [DATA_W-1:0] lq_data_i,
  input  logic              lq_eod_i,
  output logic              lq_ready_o,
  input  logic              sa_push_i,
  input  logic [ADDR_W-1:0] sa_addr_i,
  output logic              sa_ready_o,
  input  logic              sd_push_i,
  input  logic [DATA_W-1:0] sd_data_i,
  output logic              sd_ready_o,
  input  logic              op_read_i,
  input  logic              eod_branch_i,
  output logic              op_valid_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_eod_o,
  output logic              branch_taken_o,
  output logic              eod_misuse_o,
  output logic              op_stall_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i
);
  localparam int unsigned LW = DATA_W + 1;

  logic [LW-1:0]     lq_head;
  logic              lq_pop;
  logic              sa_valid, sd_valid, st_pop;
  logic [ADDR_W-1:0] sa_head;
  logic [DATA_W-1:0] sd_head;

  dq_fifo #(.W(LW), .DEPTH(DEPTH)) u_lq (
    .clk_i, .rst_ni,
    .push_i(lq_push_i), .push_data_i({lq_eod_i, lq_data_i}), .push_ready_o(lq_ready_o),
    .pop_i(lq_pop), .head_valid_o(op_valid_o), .head_data_o(lq_head)
  );

  dq_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_saq (
    .clk_i, .rst_ni,
    .push_i(sa_push_i), .push_data_i(sa_addr_i), .push_ready_o(sa_ready_o),
    .pop_i(st_pop), .head_valid_o(sa_valid), .head_data_o(sa_head)
  );

  dq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_sdq (
    .clk_i, .rst_ni,
    .push_i(sd_push_i), .push_data_i(sd_data_i), .push_ready_o(sd_ready_o),
    .pop_i(st_pop), .head_valid_o(sd_valid), .head_data_o(sd_head)
  );

  assign op_data_o = lq_head[DATA_W-1:0];
  assign op_eod_o  = lq_head[DATA_W];

  dq_load_port u_port (
    .head_valid_i(op_valid_o), .head_eod_i(op_eod_o),
    .read_i(op_read_i), .branch_i(eod_branch_i),
    .pop_o(lq_pop), .taken_o(branch_taken_o),
    .misuse_o(eod_misuse_o), .stall_o(op_stall_o)
  );

  dq_store_pair #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pair (
    .clk_i, .rst_ni,
    .addr_valid_i(sa_valid), .addr_i(sa_head),
    .data_valid_i(sd_valid), .data_i(sd_head),
    .pop_o(st_pop),
    .wr_valid_o, .wr_addr_o, .wr_data_o, .wr_ready_i
  );

  // R7: a token read as an operand stays at the head
  a_r7_token_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eod_misuse_o && !eod_branch_i) |=> (op_valid_o && op_eod_o));
endmodule

// File: tb/dq_fabric_test.sv
module dq_fabric_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 128;

  logic        clk = 0, rst_ni = 0;
  logic        lq_push = 0, lq_eod = 0, sa_push = 0, sd_push = 0;
  logic [31:0] lq_data = 0, sa_addr = 0, sd_data = 0;
  logic        op_read = 0, eod_branch = 0, wr_ready = 0;
  logic        lq_ready, sa_ready, sd_ready, op_valid, op_eod;
  logic [31:0] op_data, wr_addr, wr_data;
  logic        taken, misuse, stall, wr_valid;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [32:0] mq_ld[$];
  logic [31:0] mq_sa[$], mq_sd[$];

  always #(CLK_P/2) clk = ~clk;

  dq_fabric uut (
    .clk_i(clk), .rst_ni,
    .lq_push_i(lq_push), .lq_data_i(lq_data), .lq_eod_i(lq_eod), .lq_ready_o(lq_ready),
    .sa_push_i(sa_push), .sa_addr_i(sa_addr), .sa_ready_o(sa_ready),
    .sd_push_i(sd_push), .sd_data_i(sd_data), .sd_ready_o(sd_ready),
    .op_read_i(op_read), .eod_branch_i(eod_branch),
    .op_valid_o(op_valid), .op_data_o(op_data), .op_eod_o(op_eod),
    .branch_taken_o(taken), .eod_misuse_o(misuse), .op_stall_o(stall),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ready_i(wr_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input bit hv, input bit he, input bit rd, input bit br);
    // {taken, misuse, stall, pop}
    exp_flags[3] = br && hv && he;
    exp_flags[2] = rd && hv && he;
    exp_flags[1] = (rd || br) && !hv;
    exp_flags[0] = hv && ((he && br) || (!he && rd));
  endfunction

  // Called one step after a rising edge; checks, then advances the model across the next edge.
  task automatic cyc(input bit lv, input logic [31:0] ld, input bit le,
                     input bit sv, input logic [31:0] sa,
                     input bit dv, input logic [31:0] sd,
                     input bit rd, input bit br, input bit wr);
    bit hv, he, sp;
    logic [31:0] hd;
    logic [3:0] f;
    int nl, ns, nd;
    lq_push = lv; lq_data = ld; lq_eod = le;
    sa_push = sv; sa_addr = sa; sd_push = dv; sd_data = sd;
    op_read = rd; eod_branch = br; wr_ready = wr;
    #1;
    nl = mq_ld.size(); ns = mq_sa.size(); nd = mq_sd.size();
    hv = nl > 0;
    he = hv ? mq_ld[0][32] : 1'b0;
    hd = hv ? mq_ld[0][31:0] : 32'h0;
    f  = exp_flags(hv, he, rd, br);
    chk(op_valid == hv && (!hv || (op_eod == he && op_data == hd)), "R2 load head",
        {63'h0, op_valid, op_eod, op_data}, {63'h0, hv, he, hd});
    chk({lq_ready, sa_ready, sd_ready} == {nl < DEPTH, ns < DEPTH, nd < DEPTH}, "R3 ready",
        {93'h0, lq_ready, sa_ready, sd_ready}, {93'h0, nl < DEPTH, ns < DEPTH, nd < DEPTH});
    chk({taken, misuse, stall} == f[3:1], "R6 R7 R8 flags",
        {93'h0, taken, misuse, stall}, {93'h0, f[3:1]});
    sp = (ns > 0) && (nd > 0);
    chk(wr_valid == sp && (!sp || (wr_addr == mq_sa[0] && wr_data == mq_sd[0])), "R4 R5 write",
        {31'h0, wr_valid, wr_addr, wr_data},
        {31'h0, sp, sp ? mq_sa[0] : 32'h0, sp ? mq_sd[0] : 32'h0});
    @(posedge clk);
    if (f[0]) void'(mq_ld.pop_front());
    if (lv && nl < DEPTH) mq_ld.push_back({le, ld});
    if (sp && wr) begin void'(mq_sa.pop_front()); void'(mq_sd.pop_front()); end
    if (sv && ns < DEPTH) mq_sa.push_back(sa);
    if (dv && nd < DEPTH) mq_sd.push_back(sd);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5c_0a11));
    #(CLK_P * 2 + 2);
    // R1: reset state
    chk({lq_ready, sa_ready, sd_ready, op_valid, wr_valid, taken, misuse, stall} == 8'b1110_0000,
        "R1 reset", {88'h0, lq_ready, sa_ready, sd_ready, op_valid, wr_valid, taken, misuse, stall},
        {88'h0, 8'b1110_0000});
    @(negedge clk); rst_ni = 1;
    @(posedge clk); #1;

    // R9: single push visible right after the edge
    cyc(1, 32'hA5A5_0001, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(op_valid && op_data == 32'hA5A5_0001, "R9 visible", {95'h0, op_valid}, {95'h0, 1'b1});

    // R8: read on empty stalls
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R6/R7: data, then token; branch on data not taken, misuse keeps token, branch removes it
    cyc(1, 32'h11, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h22, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk(op_valid && op_eod, "R7 token kept", {94'h0, op_valid, op_eod}, {94'h0, 2'b11});
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk(!op_valid, "R6 token removed", {95'h0, op_valid}, 96'h0);

    // R3: fill load queue, extra pushes dropped, drain in order
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, 32'h1000 + i, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(!lq_ready, "R3 full", {95'h0, lq_ready}, 96'h0);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk(!op_valid, "R3 dropped pushes", {95'h0, op_valid}, 96'h0);

    // R4/R5: address only, then data, then hold with ready low
    cyc(0, 0, 0, 1, 32'hC000_0010, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 32'hC000_0014, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 32'hD0, 0, 0, 0);
    idle(4);
    cyc(0, 0, 0, 0, 0, 1, 32'hD1, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(!wr_valid, "R4 drained", {95'h0, wr_valid}, 96'h0);

    // R3 on store queues
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 1, i, 0, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 0, 0, 1, 32'hE00 + i, 0, 0, 1);
    idle(3);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int bias = (i / 1000) % 3;
      cyc(($urandom % 4) < (bias == 0 ? 3 : 1), $urandom, ($urandom % 6) == 0,
          ($urandom % 4) < (bias == 1 ? 3 : 2), $urandom,
          ($urandom % 4) < 2, $urandom,
          ($urandom % 4) < (bias == 2 ? 3 : 1), ($urandom % 4) == 0,
          ($urandom % 3) != 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule